// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two two's-complement operands over several clock cycles, one multiplier bit per cycle. A one-cycle start pulse loads the multiplicand into a holding register. It also loads the multiplier into the low half of a shifting accumulator whose high half is cleared. A single tail bit to the right of the accumulator starts at zero.

On each cycle the block looks at the accumulator's least significant bit and the tail bit. It subtracts the multiplicand from the high half, adds it, or leaves the high half alone. It then shifts the whole accumulator and tail one place to the right, copying the sign bit. After as many steps as the multiplier has bits, the accumulator holds the signed product. The block raises a one-cycle completion pulse, and the product is held until the next accepted start.

The high half carries one guard bit beyond the multiplicand width. Because of that bit, adding or subtracting the most negative multiplicand never wraps inside a step.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is held and after it is released with no start, `busy` and `done` are 0 and `product` is all zeros.
- R2: A start seen while `busy` is 0 is accepted: `busy` is 1 from the next cycle. `mcand` and `mplier` are captured at that edge, and later changes to them have no effect on the result.
- R3: After an accepted start, `busy` stays 1 for exactly MPLIER_W cycles. `done` is 1 for exactly one cycle right after the last step, `busy` is 0 in that cycle, and `busy` and `done` are never 1 together.
- R4: When `done` is 1, `product` equals the two's-complement product of the captured operands, written as MCAND_W+MPLIER_W bits.
- R5: The extreme operands give the exact product. For 8-bit operands: -128 times -128 gives 16'h4000, -128 times 127 gives 16'hC080, and 127 times 127 gives 16'h3F01.
- R6: A start seen while `busy` is 1 is ignored. The running operation finishes on its original schedule with the product of the operands first captured.
- R7: While `busy` is 0 and no start arrives, `product` holds its value.
- R8: With 5-bit operands, +11 (5'b01011) times -3 (5'b11101) gives 10'b1111011111 (-33).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | MCAND_W | Signed multiplicand |
| mplier | input | MPLIER_W | Signed multiplier |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | MCAND_W+MPLIER_W | Signed product |

## Verification
The hardest situation to reach from the ports is a subtract step with the most negative multiplicand. In that step the high half must briefly hold a value one bit wider than the multiplicand, which only matters when the multiplier also has the right bit pattern. The stimulus forces this with directed pairs at both extremes. The constrained-random operands are also biased toward the two ends of the range. Extra start pulses are injected at varied points of a running operation, so that an ignored start is shown to change neither the schedule nor the result.

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int MCAND_W  = 8,
  parameter int MPLIER_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [MCAND_W-1:0]          mcand,
  input  logic [MPLIER_W-1:0]         mplier,
  output logic                        busy,
  output logic                        done,
  output logic [MCAND_W+MPLIER_W-1:0] product
);
  localparam int HI_W  = MCAND_W + 1;
  localparam int CNT_W = $clog2(MPLIER_W + 1);

  logic [HI_W-1:0]     hi_q;
  logic [MPLIER_W-1:0] lo_q;
  logic                tail_q;
  logic [MCAND_W-1:0]  md_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [HI_W-1:0]     hi_sum;

  wire             accept = start && !busy;
  wire             last   = (cnt_q == CNT_W'(MPLIER_W - 1));
  wire [HI_W-1:0]  md_ext = {md_q[MCAND_W-1], md_q};

  always_comb begin
    case ({lo_q[0], tail_q})
      2'b10:   hi_sum = hi_q - md_ext;
      2'b01:   hi_sum = hi_q + md_ext;
      default: hi_sum = hi_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      tail_q <= 1'b0;
      md_q   <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        hi_q   <= '0;
        lo_q   <= mplier;
        tail_q <= 1'b0;
        md_q   <= mcand;
        cnt_q  <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        hi_q   <= {hi_sum[HI_W-1], hi_sum[HI_W-1:1]};
        lo_q   <= {hi_sum[0], lo_q[MPLIER_W-1:1]};
        tail_q <= lo_q[0];
        cnt_q  <= cnt_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = {hi_q[MCAND_W-1:0], lo_q};

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R6
  busy_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));

  // R7
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/booth_seq_mul_tb_top.sv
module booth_seq_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int BW = 8;
  localparam int PW = AW + BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] mcand = '0;
  logic [BW-1:0] mplier = '0;
  logic busy, done;
  logic [PW-1:0] product;

  logic start5 = 1'b0;
  logic [4:0] mcand5 = '0;
  logic [4:0] mplier5 = '0;
  logic busy5, done5;
  logic [9:0] product5;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_seq_mul #(.MCAND_W(AW), .MPLIER_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product));

  booth_seq_mul #(.MCAND_W(5), .MPLIER_W(5)) dut5_i (
    .clk(clk), .rst_n(rst_n), .start(start5), .mcand(mcand5), .mplier(mplier5),
    .busy(busy5), .done(done5), .product(product5));

  function automatic logic [PW-1:0] ref_mul(input logic [AW-1:0] a, input logic [BW-1:0] b);
    logic [PW-1:0] ea, eb;
    ea = {{BW{a[AW-1]}}, a};
    eb = {{AW{b[BW-1]}}, b};
    return ea * eb;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic run(input logic [AW-1:0] a, input logic [BW-1:0] b,
                     input int poke_at, input string req);
    logic [PW-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 32'(busy), 32'd1);
    mcand = ~a; mplier = ~b;
    for (int i = 1; i < BW; i++) begin
      if (i == poke_at) begin
        start = 1'b1; mcand = 8'h55; mplier = 8'h33;
      end
      @(negedge clk);
      start = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0)
        check("R3 busy window", {30'd0, busy, done}, 32'd2);
      if (poke_at == i) check("R6 start ignored while busy", 32'(busy), 32'd1);
    end
    @(negedge clk);
    check("R3 done after last step", {30'd0, busy, done}, 32'd1);
    check(req, 32'(product), 32'(exp));
    if (poke_at > 0) check("R6 original operands", 32'(product), 32'(exp));
    @(negedge clk);
    check("R3 done is one cycle", 32'(done), 32'd0);
    repeat (2) @(negedge clk);
    check("R7 product held", 32'(product), 32'(exp));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset product", 32'(product), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {15'd0, busy, done, product}, 32'd0);

    run(8'd11, 8'hFD, 0, "R4 11*-3");
    run(8'h80, 8'h80, 0, "R5 -128*-128");
    check("R5 -128*-128 value", 32'(product), 32'h4000);
    run(8'h80, 8'h7F, 0, "R5 -128*127");
    check("R5 -128*127 value", 32'(product), 32'hC080);
    run(8'h7F, 8'h7F, 0, "R5 127*127");
    check("R5 127*127 value", 32'(product), 32'h3F01);
    run(8'h7F, 8'h80, 3, "R5 127*-128");
    run(8'h00, 8'hFF, 0, "R4 0*-1");
    run(8'hFF, 8'hFF, 5, "R4 -1*-1");
    run(8'hAA, 8'h55, 1, "R4 alternating bits");

    for (int n = 0; n < 150; n++) begin
      logic [AW-1:0] a;
      logic [BW-1:0] b;
      int mode;
      mode = int'($urandom_range(0, 3));
      a = AW'($urandom);
      b = BW'($urandom);
      if (mode == 0) a = {a[AW-1], {(AW-1){a[AW-1] ? 1'b0 : 1'b1}}};
      if (mode == 1) b = {b[BW-1], {(BW-1){b[BW-1] ? 1'b0 : 1'b1}}};
      run(a, b, int'($urandom_range(0, BW - 1)), "R4 random product");
    end

    @(negedge clk);
    start5 = 1'b1; mcand5 = 5'b01011; mplier5 = 5'b11101;
    @(negedge clk);
    start5 = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 5-bit done", 32'(done5), 32'd1);
    check("R8 11*-3 5-bit", 32'(product5), 32'b1111011111);

    finish_run();
  end
endmodule